// File: doc/BRIEF.md
# Sound Timer Interrupt Router

This block contains three 8-bit interval timers that run from a shared sample-rate tick. It collects their overflows and a few software-settable test sources into two independent interrupt banks. One bank serves the local sound processor. The other serves the main processor, through a sound-request line into the main-side interrupt controller. Each bank has an enable register, a read-only pending register and a write-one-to-clear reset register. Software reaches them over a small synchronous register bus.

Each timer register holds an 8-bit count and a 3-bit prescale code. A timer with code n advances once every 2^n sample ticks. It wraps from 0xFF to 0x00 and keeps counting. Every wrap is an overflow event for both banks. The sound bank always records an event. The main bank records it only while the matching main enable bit is set. The sound interrupt is the OR of pending bits that are also enabled. The sound request is the OR of the main pending bits.

Top module: `snd_irq_timers`

## Requirements
- R1: After a synchronous reset, all registers read 0, and `snd_irq` and `snd_req` are low.
- R2: A timer register (A at 0x18, B at 0x1A, C at 0x1C) takes its count in bits 7:0 and its prescale code in bits 10:8. Writing it loads both values and restarts the prescaler. A read returns {code, current count}, and data bits above 10 are dropped.
- R3: A timer loaded with count c and code n overflows after exactly (256-c)*2^n sample ticks. It then continues from 0x00, so its next overflow comes after 256*2^n ticks. An overflow of A, B or C sets sound pending bit 6, 7 or 8.
- R4: `snd_irq` is high one cycle after any sound pending bit (0x20) is set together with its sound enable bit (0x1E). Otherwise it is low.
- R5: An event sets a main pending bit (0x2C) only if the matching main enable bit (0x2A) is set in that cycle. `snd_req` is high one cycle after any main pending bit is set.
- R6: Writes to the pending offsets 0x20 and 0x2C have no effect.
- R7: Writing 1s to a reset register (0x22 for the sound bank, 0x2E for the main bank) clears those pending bits. Bits written as 0, and the other bank, are left untouched.
- R8: When a clear and a new event for the same bit fall in the same cycle, the bit remains set.
- R9: Writing 1s to 0x24 (sound bank) or 0x26 (main bank) raises the non-timer pending bits 0 to 5, 9 and 10 as events. Timer positions 6 to 8 are ignored. The main bank's forced bits still need their enable bit.
- R10: `bus_rdata` returns the register at `bus_addr` one clock after the address is presented. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle sample-rate tick driving the prescalers |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| snd_irq | output | 1 | Interrupt to the sound processor |
| snd_req | output | 1 | Sound request toward the main interrupt controller |

## Verification
The assertions check four rules on every cycle:
- Both outputs follow the pending and enable state one cycle later.
- A pending bit only falls after a write to its own reset register.
- A main pending bit only rises while it is enabled.
- A clear that coincides with an overflow loses.

The exact overflow counts for each prescale code, the wrap-around period, the register layout and the rejection of writes to pending offsets are shown by the bench scenarios. Those scenarios sweep each timer over several count and prescale pairs and compare the result against the tick counts computed in the bench.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
  localparam int ADDR_W = 6;
  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFF_TMR0   = 6'h18; // timers at +2 steps
  localparam logic [ADDR_W-1:0] OFF_SEN    = 6'h1E;
  localparam logic [ADDR_W-1:0] OFF_SPEND  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_SCLR   = 6'h22;
  localparam logic [ADDR_W-1:0] OFF_SFORCE = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_MFORCE = 6'h26;
  localparam logic [ADDR_W-1:0] OFF_MEN    = 6'h2A;
  localparam logic [ADDR_W-1:0] OFF_MPEND  = 6'h2C;
  localparam logic [ADDR_W-1:0] OFF_MCLR   = 6'h2E;
endpackage

// File: rtl/snd_tick_timer.sv
module snd_tick_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic [PRE_W-1:0] ld_pre,
  output logic [CNT_W-1:0] cnt,
  output logic [PRE_W-1:0] pre,
  output logic             ovf
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] mask;
  logic             step;

  // low 'pre' bits of the divider all ones -> one step per 2^pre ticks
  assign mask = ~({DIV_W{1'b1}} << pre);
  assign step = tick && (&(div | ~mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pre <= '0;
      div <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (ld) begin
        cnt <= ld_cnt;
        pre <= ld_pre;
        div <= '0;
      end else if (tick) begin
        div <= div + 1'b1;
        if (step) begin
          cnt <= cnt + 1'b1;
          ovf <= &cnt;
        end
      end
    end
  end
endmodule

// File: rtl/snd_irq_bank.sv
module snd_irq_bank #(
  parameter int SRC_W     = 11,
  parameter bit MAIN_SIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] ev,
  input  logic             en_we,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] en,
  output logic [SRC_W-1:0] pend,
  output logic             any
);
  logic [SRC_W-1:0] set_v;
  logic [SRC_W-1:0] clr_v;
  logic             any_d;

  assign clr_v = clr_we ? wdata : '0;

  generate
    if (MAIN_SIDE) begin : g_main
      assign set_v = ev & en;
      assign any_d = |pend;
    end else begin : g_snd
      assign set_v = ev;
      assign any_d = |(pend & en);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      pend <= '0;
      any  <= 1'b0;
    end else begin
      if (en_we) en <= wdata;
      pend <= (pend & ~clr_v) | set_v; // set has priority
      any  <= any_d;
    end
  end
endmodule

// File: rtl/snd_irq_timers.sv
module snd_irq_timers
  import snd_irq_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 3,
  parameter int SRC_W   = 11,
  parameter int TMR_LSB = 6,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              snd_irq,
  output logic              snd_req
);
  localparam logic [SRC_W-1:0] TMR_MASK = SRC_W'(((1 << NUM_TMR) - 1) << TMR_LSB);

  logic [CNT_W-1:0]   t_cnt [NUM_TMR];
  logic [PRE_W-1:0]   t_pre [NUM_TMR];
  logic [NUM_TMR-1:0] t_ovf;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      logic t_ld;
      assign t_ld = bus_we && (bus_addr == ADDR_W'(OFF_TMR0 + 2 * gi));
      snd_tick_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick   (smp_tick),
        .ld     (t_ld),
        .ld_cnt (bus_wdata[CNT_W-1:0]),
        .ld_pre (bus_wdata[CNT_W +: PRE_W]),
        .cnt    (t_cnt[gi]),
        .pre    (t_pre[gi]),
        .ovf    (t_ovf[gi])
      );
    end
  endgenerate

  logic [SRC_W-1:0] wsrc;
  logic [SRC_W-1:0] tmr_ev, s_ev, m_ev;
  logic unused_hi;

  assign wsrc      = bus_wdata[SRC_W-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:SRC_W];

  always_comb begin
    tmr_ev = '0;
    tmr_ev[TMR_LSB +: NUM_TMR] = t_ovf;
  end

  assign s_ev = tmr_ev | ((bus_we && bus_addr == OFF_SFORCE) ? (wsrc & ~TMR_MASK) : '0);
  assign m_ev = tmr_ev | ((bus_we && bus_addr == OFF_MFORCE) ? (wsrc & ~TMR_MASK) : '0);

  logic [SRC_W-1:0] s_en, s_pend, m_en, m_pend;

  snd_irq_bank #(.SRC_W(SRC_W), .MAIN_SIDE(1'b0)) u_snd_bank (
    .clk    (clk),
    .rst    (rst),
    .ev     (s_ev),
    .en_we  (bus_we && bus_addr == OFF_SEN),
    .clr_we (bus_we && bus_addr == OFF_SCLR),
    .wdata  (wsrc),
    .en     (s_en),
    .pend   (s_pend),
    .any    (snd_irq)
  );

  snd_irq_bank #(.SRC_W(SRC_W), .MAIN_SIDE(1'b1)) u_main_bank (
    .clk    (clk),
    .rst    (rst),
    .ev     (m_ev),
    .en_we  (bus_we && bus_addr == OFF_MEN),
    .clr_we (bus_we && bus_addr == OFF_MCLR),
    .wdata  (wsrc),
    .en     (m_en),
    .pend   (m_pend),
    .any    (snd_req)
  );

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      OFF_SEN:   rd_next = DATA_W'(s_en);
      OFF_SPEND: rd_next = DATA_W'(s_pend);
      OFF_MEN:   rd_next = DATA_W'(m_en);
      OFF_MPEND: rd_next = DATA_W'(m_pend);
      default:   rd_next = '0;
    endcase
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == ADDR_W'(OFF_TMR0 + 2 * i))
        rd_next = DATA_W'({t_pre[i], t_cnt[i]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/snd_irq_chk.sv
module snd_irq_chk
  import snd_irq_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int SRC_W   = 11,
  parameter int TMR_LSB = 6,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_TMR-1:0] t_ovf,
  input logic [SRC_W-1:0]   snd_pend,
  input logic [SRC_W-1:0]   snd_en,
  input logic [SRC_W-1:0]   main_pend,
  input logic [SRC_W-1:0]   main_en,
  input logic               snd_irq,
  input logic               snd_req
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!snd_irq && !snd_req));

  // R4
  snd_irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    snd_irq == $past(|(snd_pend & snd_en)));

  // R5
  main_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (main_pend & ~$past(main_pend) & ~$past(main_en)) == '0);

  // R5
  req_follow_chk: assert property (@(posedge clk) disable iff (rst)
    snd_req == $past(|main_pend));

  // R7
  snd_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(snd_pend) & ~snd_pend)) |-> $past(bus_we && bus_addr == OFF_SCLR));

  // R7
  main_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(main_pend) & ~main_pend)) |-> $past(bus_we && bus_addr == OFF_MCLR));

  // R6
  pend_ro_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_we && bus_addr == OFF_SPEND) && !$past(|t_ovf)) |-> snd_pend == $past(snd_pend));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(t_ovf[0] && bus_we && bus_addr == OFF_SCLR && bus_wdata[TMR_LSB]) |-> snd_pend[TMR_LSB]);
endmodule

bind snd_irq_timers snd_irq_chk #(
  .NUM_TMR(NUM_TMR), .SRC_W(SRC_W), .TMR_LSB(TMR_LSB), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .t_ovf     (t_ovf),
  .snd_pend  (s_pend),
  .snd_en    (s_en),
  .main_pend (m_pend),
  .main_en   (m_en),
  .snd_irq   (snd_irq),
  .snd_req   (snd_req)
);

// File: tb/tb_snd_irq_timers.sv
module tb_snd_irq_timers;
  localparam int CLK_P = 10;

  localparam logic [5:0] A_TA = 6'h18, A_TB = 6'h1A, A_TC = 6'h1C;
  localparam logic [5:0] A_SEN = 6'h1E, A_SPD = 6'h20, A_SCL = 6'h22, A_SFO = 6'h24;
  localparam logic [5:0] A_MFO = 6'h26, A_MEN = 6'h2A, A_MPD = 6'h2C, A_MCL = 6'h2E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        snd_irq, snd_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  snd_irq_timers dut (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snd_irq(snd_irq), .snd_req(snd_req)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_tick = 1'b1;
    end
    @(negedge clk);
    smp_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // slowest prescale, count 0: far from overflow; clear both banks
  task automatic park();
    wr(A_TA, 16'h0700); wr(A_TB, 16'h0700); wr(A_TC, 16'h0700);
    wr(A_SCL, 16'h07FF); wr(A_MCL, 16'h07FF);
    wr(A_SEN, 16'h0000); wr(A_MEN, 16'h0000);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int c, n, nt;
    idle(5);
    rst = 1'b0;

    // R1 reset state
    chk("R1 snd_irq", snd_irq, 0);
    chk("R1 snd_req", snd_req, 0);
    rd(A_TA, v);  chk("R1 timer A", v, 0);
    rd(A_SPD, v); chk("R1 sound pending", v, 0);
    rd(A_MEN, v); chk("R1 main enable", v, 0);

    // R2 layout, load, prescaler restart
    park();
    wr(A_TA, 16'h0310);
    rd(A_TA, v); chk("R2 readback", v, 16'h0310);
    ticks(7);
    rd(A_TA, v); chk("R2 no step before 8 ticks", v, 16'h0310);
    ticks(1);
    rd(A_TA, v); chk("R2 step at 8 ticks", v, 16'h0311);
    wr(A_TB, 16'hF8FF);
    rd(A_TB, v); chk("R2 upper bits dropped", v, 16'h00FF);

    // R10 unmapped read
    rd(6'h3E, v); chk("R10 unmapped", v, 0);

    // R3 sweep: every timer, several count/prescale pairs
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: begin c = 8'hF0; n = 0; end
          1: begin c = 8'hFE; n = 3; end
          2: begin c = 8'hF8; n = 2; end
          default: begin c = 8'hFF; n = 7; end
        endcase
        nt = (256 - c) << n;
        park();
        wr(A_TA + 6'(2 * t), 16'((n << 8) | c));
        ticks(nt - 1);
        idle(2);
        rd(A_SPD, v); chk("R3 before overflow", v, 0);
        ticks(1);
        idle(2);
        rd(A_SPD, v); chk("R3 at overflow", v, 16'(1 << (6 + t)));
        rd(A_MPD, v); chk("R5 main not enabled", v, 0);
      end
    end

    // R3 wrap period
    park();
    wr(A_TA, 16'h00F0);
    ticks(16);
    wr(A_SCL, 16'h0040);
    ticks(255);
    idle(2);
    rd(A_SPD, v); chk("R3 wrap not yet", v, 0);
    ticks(1);
    idle(2);
    rd(A_SPD, v); chk("R3 wrap overflow", v, 16'h0040);

    // R5 main path via timer B
    park();
    wr(A_MEN, 16'h0080);
    wr(A_TB, 16'h00FE);
    ticks(2);
    idle(2);
    rd(A_MPD, v); chk("R5 main pending B", v, 16'h0080);
    rd(A_SPD, v); chk("R3 sound pending B", v, 16'h0080);
    chk("R5 snd_req", snd_req, 1);
    chk("R4 irq disabled", snd_irq, 0);
    wr(A_SEN, 16'h0080);
    idle(2);
    chk("R4 irq enabled", snd_irq, 1);
    wr(A_MCL, 16'h0080);
    idle(2);
    chk("R5 snd_req cleared", snd_req, 0);
    rd(A_SPD, v); chk("R7 other bank untouched", v, 16'h0080);

    // R6 pending read-only
    wr(A_SPD, 16'hFFFF);
    wr(A_MPD, 16'hFFFF);
    rd(A_SPD, v); chk("R6 sound pending", v, 16'h0080);
    rd(A_MPD, v); chk("R6 main pending", v, 0);

    // R9 software sources
    park();
    wr(A_SFO, 16'hFFFF);
    rd(A_SPD, v); chk("R9 sound force", v, 16'h063F);
    wr(A_MFO, 16'h07FF);
    rd(A_MPD, v); chk("R9 main force gated", v, 0);
    wr(A_MEN, 16'h0003);
    wr(A_MFO, 16'h07FF);
    rd(A_MPD, v); chk("R9 main force enabled", v, 16'h0003);
    rd(A_MEN, v); chk("R10 enable readback", v, 16'h0003);

    // R4 / R7 selective clear
    wr(A_SEN, 16'h0001);
    idle(2);
    chk("R4 irq bit0", snd_irq, 1);
    wr(A_SCL, 16'h0001);
    idle(2);
    rd(A_SPD, v); chk("R7 zero bits kept", v, 16'h063E);
    chk("R4 irq drops", snd_irq, 0);

    // R8 clear collides with overflow
    park();
    wr(A_SFO, 16'h0000);
    wr(A_TA, 16'h00FF);
    ticks(1);
    idle(2);
    rd(A_SPD, v); chk("R8 setup", v, 16'h0040);
    wr(A_TA, 16'h00FF);
    @(negedge clk);
    smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
    bus_we = 1'b1; bus_addr = A_SCL; bus_wdata = 16'h0040;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_SPD, v); chk("R8 set wins", v, 16'h0040);
    wr(A_SCL, 16'h0040);
    rd(A_SPD, v); chk("R7 plain clear", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule